// File: doc/BRIEF.md
# Head Step Pulse Sequencer

This block drives the two positioning lines of a floppy-style disk drive: an active-low step strobe and a direction level. The host raises a one-cycle request with a direction flag (toward or away from the disk centre) and a step count. The block first drives the direction line and holds it for a setup interval. It then pulls the step line low for a fixed number of cycles. The head starts to move on the step line's rising (trailing) edge, so the direction is kept steady through a hold interval after that edge. Done is then strobed for one cycle.

A count above one issues a train of pulses whose trailing edges are spaced by a fixed step-rate interval. The direction stays constant for the whole train. Requests are taken only while the drive select input is true and the block is idle. All timing constants are parameters in clock cycles.

Top module: `step_seq`

## Requirements
- R1: After reset, step_no is 1, dir_o is 1, busy_o is 0 and done_o is 0.
- R2: An accepted request drives dir_o on the next clock edge: dir_o = 0 when dir_in_i = 1 (toward centre) and dir_o = 1 when dir_in_i = 0 (away from centre).
- R3: Each step pulse holds step_no low for exactly PULSE_CYC cycles. The first pulse starts SETUP_CYC cycles after the accepting edge.
- R4: dir_o does not change while busy_o is high, so it is steady before every trailing edge and for HOLD_CYC cycles after the last one.
- R5: done_o is a one-cycle strobe that rises HOLD_CYC cycles after the final trailing edge. busy_o falls on the same edge.
- R6: A request with count_i = N issues N pulses, with successive trailing edges RATE_CYC cycles apart. count_i = 0 is treated as one step.
- R7: A request arriving while busy_o is high is ignored: the pulse count and dir_o are unchanged.
- R8: A request while sel_i is 0 is ignored: busy_o stays 0 and no pulse is issued.
- R9: busy_o rises on the edge that accepts a request and stays high until done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Drive selected; requests are taken only while this is 1 |
| req_i | input | 1 | Step request strobe |
| dir_in_i | input | 1 | Requested direction: 1 toward centre, 0 away |
| count_i | input | CNT_W | Number of steps (0 means 1) |
| step_no | output | 1 | Step strobe, active low |
| dir_o | output | 1 | Direction level: 0 toward centre, 1 away |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence strobe |

## Verification
Single steps are run in both directions. These show that the direction polarity is mapped correctly and that the setup, low and hold intervals land on the exact cycles. Step trains of three pulses, and a request with count zero, separate the step-rate spacing and the count decrement from the single-step path. A second request issued in the middle of a pulse, and a request made with select low, show that the block ignores input it must not accept.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_WAIT,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/step_seq_timer.sv
module step_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/step_seq_remain.sv
module step_seq_remain #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (load_i)  rem_q <= (count_i == '0) ? CNT_W'(1) : count_i;
    else if (dec_i && rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  assign last_o = (rem_q == CNT_W'(1));
endmodule

// File: rtl/step_seq_ctrl.sv
module step_seq_ctrl
  import step_seq_pkg::*;
#(
  parameter int TW        = 8,
  parameter int SETUP_CYC = 25,
  parameter int PULSE_CYC = 64,
  parameter int HOLD_CYC  = 32,
  parameter int GAP_CYC   = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_ok_i,
  input  logic          toward_i,
  input  logic          tmr_zero_i,
  input  logic          last_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          rem_load_o,
  output logic          rem_dec_o,
  output logic          step_no,
  output logic          dir_o,
  output logic          busy_o,
  output logic          done_o
);
  seq_state_e state_q, state_d;
  logic step_nq, dir_q, done_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    rem_load_o = 1'b0;
    rem_dec_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_ok_i) begin
        state_d    = ST_SETUP;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(SETUP_CYC - 1);
        rem_load_o = 1'b1;
      end
      ST_SETUP: if (tmr_zero_i) begin
        state_d    = ST_LOW;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(PULSE_CYC - 1);
      end
      ST_LOW: if (tmr_zero_i) begin
        rem_dec_o  = 1'b1;
        tmr_load_o = 1'b1;
        if (last_i) begin
          state_d   = ST_HOLD;
          tmr_val_o = TW'(HOLD_CYC - 1);
        end else begin
          state_d   = ST_WAIT;
          tmr_val_o = TW'(GAP_CYC - 1);
        end
      end
      ST_WAIT: if (tmr_zero_i) begin
        state_d    = ST_LOW;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(PULSE_CYC - 1);
      end
      ST_HOLD: if (tmr_zero_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_nq <= 1'b1;
      dir_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_nq <= (state_d != ST_LOW);
      done_q  <= (state_q == ST_HOLD) && tmr_zero_i;
      if (state_q == ST_IDLE && req_ok_i) dir_q <= ~toward_i;
    end
  end

  assign step_no = step_nq;
  assign dir_o   = dir_q;
  assign done_o  = done_q;
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/step_seq.sv
module step_seq #(
  parameter int SETUP_CYC = 25,
  parameter int PULSE_CYC = 64,
  parameter int HOLD_CYC  = 32,
  parameter int RATE_CYC  = 750,
  parameter int CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             req_i,
  input  logic             dir_in_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             step_no,
  output logic             dir_o,
  output logic             busy_o,
  output logic             done_o
);
  // spacing between trailing edges minus the low phase
  localparam int GAP_CYC = RATE_CYC - PULSE_CYC;
  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B   = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW      = $clog2(MAX_CYC + 1);

  logic          tmr_load, tmr_zero, rem_load, rem_dec, last;
  logic [TW-1:0] tmr_val;

  step_seq_timer #(.TW(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  step_seq_remain #(.CNT_W(CNT_W)) u_rem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rem_load),
    .count_i (count_i),
    .dec_i   (rem_dec),
    .last_o  (last)
  );

  step_seq_ctrl #(
    .TW        (TW),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_ok_i   (req_i && sel_i),
    .toward_i   (dir_in_i),
    .tmr_zero_i (tmr_zero),
    .last_i     (last),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .rem_load_o (rem_load),
    .rem_dec_o  (rem_dec),
    .step_no    (step_no),
    .dir_o      (dir_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk #(
  parameter int PULSE_CYC = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_i,
  input logic req_i,
  input logic step_no,
  input logic dir_o,
  input logic busy_o,
  input logic done_o
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_cnt <= '0;
    else if (!step_no) low_cnt <= low_cnt + 16'd1;
    else               low_cnt <= '0;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_no) |-> low_cnt == 16'(PULSE_CYC)); // R3
  AST_STEP_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_no |-> busy_o); // R3
  AST_DIR_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(dir_o)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R5
  AST_NOSEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_i && !sel_i |=> !busy_o); // R8
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_i && sel_i |=> busy_o); // R9
endmodule

bind step_seq step_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .req_i   (req_i),
  .step_no (step_no),
  .dir_o   (dir_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/sim_step_seq.sv
`timescale 1ns/1ps
module sim_step_seq;
  localparam int S = 4, P = 64, H = 32, R = 150, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, req = 1'b0, dir_in = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic step_n, dir, busy, done;

  int tests = 0, fails = 0;
  int cyc = 0;
  int pcount = 0, dcount = 0, dir_bad = 0, done_cyc = 0;
  int fall_c [64];
  int rise_c [64];
  logic prev_step = 1'b1, prev_busy = 1'b0, prev_dir = 1'b1;

  always #2 clk = ~clk;

  step_seq #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .RATE_CYC(R), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .req_i(req), .dir_in_i(dir_in),
    .count_i(cnt), .step_no(step_n), .dir_o(dir), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (prev_step && !step_n && pcount < 64) fall_c[pcount] = cyc;
    if (!prev_step && step_n && pcount < 64) begin
      rise_c[pcount] = cyc;
      pcount++;
    end
    if (busy && prev_busy && dir != prev_dir) dir_bad++;
    if (done) begin
      dcount++;
      done_cyc = cyc;
    end
    prev_step = step_n;
    prev_busy = busy;
    prev_dir  = dir;
  end

  task automatic chk(input string req_tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic issue(input logic s, input logic d, input logic [CW-1:0] n, output int acc);
    @(negedge clk);
    sel = s; dir_in = d; cnt = n; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    acc = cyc;
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 4000 && dcount == d0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 step", step_n, 1);
    chk("R1 dir", dir, 1);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_single(input logic toward);
    int a, p0, d0, b0;
    p0 = pcount; d0 = dcount; b0 = dir_bad;
    issue(1'b1, toward, 4'd1, a);
    chk("R2 dir", dir, toward ? 0 : 1);
    chk("R9 busy", busy, 1);
    wait_done(d0);
    chk("R3 count", pcount - p0, 1);
    chk("R3 fall", fall_c[p0], a + S);
    chk("R3 rise", rise_c[p0], a + S + P);
    chk("R5 done", done_cyc, a + S + P + H);
    chk("R5 strobes", dcount - d0, 1);
    chk("R4 dir", dir_bad - b0, 0);
    chk("R5 busy", busy, 0);
  endtask

  task automatic t_multi(input logic [CW-1:0] n);
    int a, p0, d0, exp_n;
    exp_n = (n == 0) ? 1 : int'(n);
    p0 = pcount; d0 = dcount;
    issue(1'b1, 1'b0, n, a);
    wait_done(d0);
    chk("R6 pulses", pcount - p0, exp_n);
    for (int k = 1; k < exp_n; k++)
      chk("R6 spacing", rise_c[p0 + k] - rise_c[p0 + k - 1], R);
    chk("R5 done", done_cyc, a + S + P + (exp_n - 1) * R + H);
  endtask

  task automatic t_busy_ignore();
    int a, a2, p0, d0;
    p0 = pcount; d0 = dcount;
    issue(1'b1, 1'b0, 4'd1, a);
    repeat (S + 10) @(negedge clk);
    issue(1'b1, 1'b1, 4'd3, a2);
    chk("R7 dir", dir, 1);
    wait_done(d0);
    repeat (R + P) @(negedge clk);
    chk("R7 pulses", pcount - p0, 1);
    chk("R7 busy", busy, 0);
  endtask

  task automatic t_nosel();
    int a, p0;
    p0 = pcount;
    issue(1'b0, 1'b1, 4'd2, a);
    chk("R8 busy", busy, 0);
    repeat (S + P + 20) @(negedge clk);
    chk("R8 pulses", pcount - p0, 0);
    chk("R8 dir", dir, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single(1'b1);
    t_single(1'b0);
    t_multi(4'd3);
    t_multi(4'd0);
    t_busy_ignore();
    t_nosel();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule